// File: doc/BRIEF.md
# Programmable 16-bit Target Timer

A general-purpose timer built around a 16-bit up-counter. Three small registers sit behind a simple single-cycle bus: a count register, a mode register and a target register. On every counting tick the counter advances by one. When the new value equals the target it records a target hit, and it can optionally restart from zero at that point. Stepping past 0xFFFF records an overflow hit and wraps to zero.

Each hit can raise a one-cycle interrupt pulse. The mode register chooses one of two styles. In one-shot style only the first enabled hit after arming produces a pulse. In repeat style every enabled hit produces one. Sticky status bits in the mode register record which hits happened. Reading the mode register returns its value and then clears the two hit-kind bits.

A build-time parameter picks the counting source. The external-tick build counts either the system tick enable or an external tick enable. The divider build counts either every system tick or every eighth system tick, and it also has a stop bit.

Top module: `tgt_timer`

## Requirements
- R1: After reset the count, mode and target registers all read as zero and `irq` is low.
- R2: Bus address 0 selects the count register, 1 the mode register and 2 the target register. In the external-tick build, mode bit 8 set makes the counter advance on `ext_tick_en`; with bit 8 clear it advances on `sys_tick_en`. In the divider build, bit 8 has no effect.
- R3: In the divider build, mode bit 9 set makes the counter advance once per eight `sys_tick_en` pulses, and mode bit 0 set stops all counting. In the external-tick build, bits 9 and 0 have no effect.
- R4: On a tick, the count becomes count+1 (modulo 2^16). A target hit is recorded when that value equals the target; if mode bit 3 is set, the count becomes 0 instead. An overflow hit is recorded when the count was 0xFFFF.
- R5: A target hit sets mode bit 11, an overflow hit sets mode bit 12, and either hit sets mode bit 10. All three bits stay set until the mode register is written.
- R6: A read of the mode register returns its current value, then clears bits 11 and 12. Bit 10 is kept. A hit in the same cycle as the read still sets its bit.
- R7: `irq` pulses high for exactly one cycle, in the cycle after a target hit with mode bit 4 set or an overflow hit with mode bit 5 set.
- R8: With mode bit 6 clear, only the first qualifying hit after a mode write pulses `irq`. With bit 6 set, every qualifying hit pulses `irq`.
- R9: A mode write stores data bits 9:0, clears bits 10 to 12, sets the count and prescaler to zero, rearms the one-shot state and cancels any pending pulse. Bits 13 to 15 always read as zero.
- R10: A target write replaces the target and leaves the count unchanged. If a tick falls in the same cycle, the count still increments, and the compare in that cycle uses the old target.
- R11: A count write loads the data into the count. In a cycle with a count or mode write, a tick neither increments the count nor records a hit.
- R12: `bus_rdata` is zero when `bus_rd` is low or the address is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick_en | input | 1 | System counting enable |
| ext_tick_en | input | 1 | External tick enable (alternate source) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 count, 1 mode, 2 target |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
Assertions check several properties on every cycle:
- a mode write zeroes the count and rearms the one-shot state;
- a count write wins over a tick;
- the count holds when there is neither a tick nor a load;
- a target match with wrap enabled returns the count to zero;
- the event bit is sticky;
- a read clears the hit-kind bits;
- a one-shot pulse is never followed by a second pulse in the next cycle;
- the prescaler restarts and freezes as required.

Other behaviours need whole scenarios, and only the bench shows them: the exact divide-by-eight cadence, the pulse count over many wraps in one-shot and repeat styles, and which source each build counts. The bench also compares every read and every `irq` cycle against a bench-side model under random bus traffic.

// File: rtl/tgt_timer_pkg.sv
package tgt_timer_pkg;

  localparam int unsigned REG_W = 16;
  localparam int unsigned CTL_W = 10;

  // mode register bit positions
  localparam int unsigned MB_STOP    = 0;
  localparam int unsigned MB_WRAP    = 3;
  localparam int unsigned MB_IRQ_TGT = 4;
  localparam int unsigned MB_IRQ_OVF = 5;
  localparam int unsigned MB_REPEAT  = 6;
  localparam int unsigned MB_ALT     = 8;
  localparam int unsigned MB_DIV     = 9;

  typedef enum logic [1:0] {
    RA_COUNT  = 2'd0,
    RA_MODE   = 2'd1,
    RA_TARGET = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/tgt_timer_tick_sel.sv
module tgt_timer_tick_sel #(
  parameter bit DIV_CAPABLE = 1'b1,
  parameter int DIV_FACTOR  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sys_tick,
  input  logic ext_tick,
  input  logic mode_stop,
  input  logic mode_alt,
  input  logic mode_div,
  output logic tick_o
);

  localparam int PRE_W = (DIV_FACTOR > 1) ? $clog2(DIV_FACTOR) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV_FACTOR - 1);

  generate
    if (DIV_CAPABLE) begin : g_div
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_adv;
      logic             unused_alt;

      assign unused_alt = mode_alt ^ ext_tick;
      assign pre_adv    = sys_tick & ~mode_stop;

      always_comb begin
        pre_d = pre_q;
        if (restart)
          pre_d = '0;
        else if (pre_adv)
          pre_d = (pre_q == PRE_LAST) ? '0 : pre_q + PRE_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          pre_q <= '0;
        else
          pre_q <= pre_d;
      end

      assign tick_o = pre_adv & (~mode_div | (pre_q == PRE_LAST));

      // R9: a mode write restarts the prescaler
      a_r9_prescale_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q == '0))
        else $error("prescaler not restarted");

      // R3: stop freezes the prescaler
      a_r3_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stop && !restart) |=> $stable(pre_q))
        else $error("prescaler moved while stopped");
    end else begin : g_ext
      logic unused_div;

      assign unused_div = restart ^ mode_stop ^ mode_div;
      assign tick_o     = mode_alt ? ext_tick : sys_tick;
    end
  endgenerate

endmodule

// File: rtl/tgt_timer_counter.sv
module tgt_timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld_zero,
  input  logic             ld_val,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] target,
  input  logic             wrap_en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_tgt_o,
  output logic             hit_ovf_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, nxt;
  logic             step;

  always_comb begin
    nxt       = cnt_q + CNT_W'(1);
    step      = tick & ~ld_zero & ~ld_val;
    hit_tgt_o = step & (nxt == target);
    hit_ovf_o = step & (cnt_q == {CNT_W{1'b1}});
    cnt_d     = cnt_q;
    if (ld_zero)
      cnt_d = '0;
    else if (ld_val)
      cnt_d = wdata;
    else if (step)
      cnt_d = (hit_tgt_o && wrap_en) ? '0 : nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R9: mode write zeroes count
  a_r9_mode_write_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    ld_zero |=> (cnt_q == '0))
    else $error("count not zero after mode write");

  // R11: count write wins over a tick
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_val && !ld_zero) |=> (cnt_q == $past(wdata)))
    else $error("count load lost");

  // R10: without tick or load the count holds (covers target writes)
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_zero && !ld_val) |=> $stable(cnt_q))
    else $error("count moved without tick");

  // R4: wrap on target returns to zero
  a_r4_wrap_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_tgt_o && wrap_en) |=> (cnt_q == '0))
    else $error("no wrap at target");

endmodule

// File: rtl/tgt_timer_status.sv
module tgt_timer_status
  import tgt_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mode,
  input  logic             rd_mode,
  input  logic [CTL_W-1:0] wdata,
  input  logic             hit_tgt,
  input  logic             hit_ovf,
  output logic [REG_W-1:0] mode_o,
  output logic             irq_o
);

  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic evt_q, evt_d, ftgt_q, ftgt_d, fovf_q, fovf_d;
  logic fired_q, fired_d, irq_q, irq_d;
  logic want_irq;

  always_comb begin
    ctl_d    = wr_mode ? wdata : ctl_q;
    want_irq = (hit_tgt & ctl_q[MB_IRQ_TGT]) | (hit_ovf & ctl_q[MB_IRQ_OVF]);
    irq_d    = ~wr_mode & want_irq & (ctl_q[MB_REPEAT] | ~fired_q);
    if (wr_mode) begin
      evt_d   = 1'b0;
      ftgt_d  = 1'b0;
      fovf_d  = 1'b0;
      fired_d = 1'b0;
    end else begin
      evt_d   = evt_q | hit_tgt | hit_ovf;
      ftgt_d  = hit_tgt | (ftgt_q & ~rd_mode);
      fovf_d  = hit_ovf | (fovf_q & ~rd_mode);
      fired_d = fired_q | irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      evt_q   <= 1'b0;
      ftgt_q  <= 1'b0;
      fovf_q  <= 1'b0;
      fired_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      evt_q   <= evt_d;
      ftgt_q  <= ftgt_d;
      fovf_q  <= fovf_d;
      fired_q <= fired_d;
      irq_q   <= irq_d;
    end
  end

  assign mode_o = {3'b000, fovf_q, ftgt_q, evt_q, ctl_q};
  assign irq_o  = irq_q;

  // R8: one-shot style never pulses twice in a row
  a_r8_one_shot_single: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ctl_q[MB_REPEAT] && !wr_mode) |=> !irq_q)
    else $error("second one-shot pulse");

  // R6: read clears hit-kind bits when no new hit
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && !wr_mode && !hit_tgt && !hit_ovf) |=> (!ftgt_q && !fovf_q))
    else $error("flags survived mode read");

  // R5: event bit is sticky until mode write
  a_r5_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !wr_mode) |=> evt_q)
    else $error("event bit lost");

  // R9: mode write rearms and cancels pulse
  a_r9_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (!fired_q && !irq_q))
    else $error("not rearmed");

endmodule

// File: rtl/tgt_timer.sv
module tgt_timer
  import tgt_timer_pkg::*;
#(
  parameter bit DIV_CAPABLE = 1'b1,
  parameter int DIV_FACTOR  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_tick_en,
  input  logic             ext_tick_en,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq
);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             wr_cnt, wr_mode, wr_tgt, rd_mode;
  logic             tick;
  logic [REG_W-1:0] tgt_q, tgt_d, cnt, mode;
  logic             hit_tgt, hit_ovf;
  reg_addr_e        addr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    addr    = reg_addr_e'(bus_addr);
    wr_cnt  = bus_wr & (addr == RA_COUNT);
    wr_mode = bus_wr & (addr == RA_MODE);
    wr_tgt  = bus_wr & (addr == RA_TARGET);
    rd_mode = bus_rd & (addr == RA_MODE);
    tgt_d   = wr_tgt ? bus_wdata : tgt_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)
      tgt_q <= '0;
    else
      tgt_q <= tgt_d;
  end

  tgt_timer_tick_sel #(
    .DIV_CAPABLE (DIV_CAPABLE),
    .DIV_FACTOR  (DIV_FACTOR)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .restart   (wr_mode),
    .sys_tick  (sys_tick_en),
    .ext_tick  (ext_tick_en),
    .mode_stop (mode[MB_STOP]),
    .mode_alt  (mode[MB_ALT]),
    .mode_div  (mode[MB_DIV]),
    .tick_o    (tick)
  );

  tgt_timer_counter #(
    .CNT_W (REG_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick      (tick),
    .ld_zero   (wr_mode),
    .ld_val    (wr_cnt),
    .wdata     (bus_wdata),
    .target    (tgt_q),
    .wrap_en   (mode[MB_WRAP]),
    .cnt_o     (cnt),
    .hit_tgt_o (hit_tgt),
    .hit_ovf_o (hit_ovf)
  );

  tgt_timer_status u_stat (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_mode (wr_mode),
    .rd_mode (rd_mode),
    .wdata   (bus_wdata[CTL_W-1:0]),
    .hit_tgt (hit_tgt),
    .hit_ovf (hit_ovf),
    .mode_o  (mode),
    .irq_o   (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (addr)
        RA_COUNT:  bus_rdata = cnt;
        RA_MODE:   bus_rdata = mode;
        RA_TARGET: bus_rdata = tgt_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R10: target write takes the bus data
  a_r10_target_load: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_tgt |=> (tgt_q == $past(bus_wdata)))
    else $error("target not loaded");

endmodule

// File: tb/tgt_timer_tb_top.sv
module tgt_timer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sys_tick_en, ext_tick_en, bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] rdata_d, rdata_x;
  logic        irq_d, irq_x;

  int checks = 0;
  int fails  = 0;

  // model state: index 0 = divider build, 1 = external-tick build
  logic [15:0] m_cnt  [2];
  logic [15:0] m_mode [2];
  logic [15:0] m_tgt  [2];
  logic [2:0]  m_pre  [2];
  logic        m_fired[2];
  logic        m_irq  [2];
  logic [15:0] last_rd[2];
  int          irq_seen[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  tgt_timer #(.DIV_CAPABLE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .sys_tick_en(sys_tick_en), .ext_tick_en(ext_tick_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_d), .irq(irq_d));

  tgt_timer #(.DIV_CAPABLE(1'b0)) dut_x (
    .clk(clk), .rst_n(rst_n), .sys_tick_en(sys_tick_en), .ext_tick_en(ext_tick_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_x), .irq(irq_x));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_read(input int v, input logic [1:0] a);
    case (a)
      2'd0:    return m_cnt[v];
      2'd1:    return m_mode[v];
      2'd2:    return m_tgt[v];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_upd(input int v, input bit wr, input bit rd, input logic [1:0] a,
                           input logic [15:0] d, input bit s, input bit e);
    bit tick, tm, ov, irqn, wmode, wcnt, wtgt, rmode;
    logic [15:0] nx;
    wmode = wr && a == 2'd1;
    wcnt  = wr && a == 2'd0;
    wtgt  = wr && a == 2'd2;
    rmode = rd && a == 2'd1;
    if (v == 0) begin
      tick = !m_mode[v][0] && s && (!m_mode[v][9] || m_pre[v] == 3'd7);
      if (wmode) m_pre[v] = 3'd0;
      else if (s && !m_mode[v][0]) m_pre[v] = m_pre[v] + 3'd1;
    end else begin
      tick = m_mode[v][8] ? e : s;
    end
    tm = 0; ov = 0;
    if (wmode) begin
      m_cnt[v]   = 16'h0000;
      m_mode[v]  = d & 16'h03FF;
      m_fired[v] = 1'b0;
      m_irq[v]   = 1'b0;
    end else begin
      if (wcnt) m_cnt[v] = d;
      else if (tick) begin
        nx = m_cnt[v] + 16'd1;
        ov = (m_cnt[v] == 16'hFFFF);
        tm = (nx == m_tgt[v]);
        m_cnt[v] = (tm && m_mode[v][3]) ? 16'h0000 : nx;
      end
      irqn = ((tm && m_mode[v][4]) || (ov && m_mode[v][5])) && (m_mode[v][6] || !m_fired[v]);
      if (rmode) m_mode[v][12:11] = 2'b00;
      if (tm) m_mode[v][11] = 1'b1;
      if (ov) m_mode[v][12] = 1'b1;
      if (tm || ov) m_mode[v][10] = 1'b1;
      if (irqn) m_fired[v] = 1'b1;
      m_irq[v] = irqn;
    end
    if (wtgt) m_tgt[v] = d;
  endtask

  // one bus cycle on both builds; reads checked against model with given tag
  task automatic cyc(input string tag, input bit wr, input bit rd, input logic [1:0] a,
                     input logic [15:0] d, input bit s, input bit e);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    sys_tick_en = s; ext_tick_en = e;
    #1;
    if (rd) begin
      last_rd[0] = rdata_d;
      last_rd[1] = rdata_x;
      check({tag, " read div"}, rdata_d, model_read(0, a));
      check({tag, " read ext"}, rdata_x, model_read(1, a));
    end else begin
      check("R12 idle rdata div", rdata_d, 16'h0000);
    end
    model_upd(0, wr, rd, a, d, s, e);
    model_upd(1, wr, rd, a, d, s, e);
    @(posedge clk);
    #1;
    check("R7 irq div", {15'd0, irq_d}, {15'd0, m_irq[0]});
    check("R7 irq ext", {15'd0, irq_x}, {15'd0, m_irq[1]});
    if (irq_d) irq_seen[0]++;
    if (irq_x) irq_seen[1]++;
  endtask

  task automatic idle(input int n, input bit s, input bit e);
    for (int i = 0; i < n; i++) cyc("idle", 0, 0, 2'd0, 16'h0, s, e);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int v = 0; v < 2; v++) begin
      m_cnt[v] = 0; m_mode[v] = 0; m_tgt[v] = 0; m_pre[v] = 0;
      m_fired[v] = 0; m_irq[v] = 0; irq_seen[v] = 0;
    end
    rst_n = 1'b0;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; sys_tick_en = 0; ext_tick_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(3, 0, 0);

    // R1 reset values
    cyc("R1", 0, 1, 2'd0, 0, 0, 0); check("R1 count", last_rd[0], 16'h0);
    cyc("R1", 0, 1, 2'd1, 0, 0, 0); check("R1 mode", last_rd[0], 16'h0);
    cyc("R1", 0, 1, 2'd2, 0, 0, 0); check("R1 target", last_rd[1], 16'h0);

    // R11 count write beats a tick
    cyc("R11", 1, 0, 2'd0, 16'h0005, 1, 1);
    cyc("R11", 0, 1, 2'd0, 0, 0, 0); check("R11 loaded", last_rd[0], 16'h0005);

    // R10 target write with tick keeps counting
    cyc("R10", 1, 0, 2'd2, 16'h0100, 1, 0);
    cyc("R10", 0, 1, 2'd0, 0, 0, 0); check("R10 count kept", last_rd[0], 16'h0006);
    cyc("R10", 0, 1, 2'd2, 0, 0, 0); check("R10 target", last_rd[0], 16'h0100);

    // R12 unmapped address and upper mode bits
    cyc("R12", 0, 1, 2'd3, 0, 0, 0); check("R12 addr3", last_rd[0], 16'h0);
    cyc("R9", 1, 0, 2'd1, 16'hFC00, 0, 0);
    cyc("R9", 0, 1, 2'd1, 0, 0, 0); check("R9 mode mask", last_rd[1], 16'h0000);

    // R8 one-shot: target 3, wrap, irq on target
    cyc("R8", 1, 0, 2'd2, 16'h0003, 0, 0);
    cyc("R9", 1, 0, 2'd1, 16'h0018, 0, 0);
    irq_seen[0] = 0; irq_seen[1] = 0;
    idle(20, 1, 0);
    check("R8 one-shot pulses", 16'(irq_seen[0]), 16'd1);
    check("R8 one-shot pulses ext", 16'(irq_seen[1]), 16'd1);
    // R6 flags then clear
    cyc("R6", 0, 1, 2'd1, 0, 0, 0);
    check("R5 flags set", last_rd[0] & 16'h1C00, 16'h0C00);
    cyc("R6", 0, 1, 2'd1, 0, 0, 0);
    check("R6 cleared", last_rd[0] & 16'h1C00, 16'h0400);

    // R8 repeat style
    cyc("R8", 1, 0, 2'd1, 16'h0058, 0, 0);
    irq_seen[0] = 0;
    idle(20, 1, 0);
    check("R8 repeat pulses", 16'(irq_seen[0]), 16'd6);

    // R3 divide by eight and stop
    cyc("R3", 1, 0, 2'd2, 16'h1000, 0, 0);
    cyc("R3", 1, 0, 2'd1, 16'h0200, 0, 0);
    idle(16, 1, 0);
    cyc("R3", 0, 1, 2'd0, 0, 0, 0);
    check("R3 div8", last_rd[0], 16'd2);
    check("R3 ext ignores bit9", last_rd[1], 16'd16);
    cyc("R3", 1, 0, 2'd1, 16'h0001, 0, 0);
    idle(10, 1, 0);
    cyc("R3", 0, 1, 2'd0, 0, 0, 0);
    check("R3 stopped", last_rd[0], 16'd0);

    // R2 external source
    cyc("R2", 1, 0, 2'd1, 16'h0100, 0, 0);
    for (int i = 0; i < 10; i++) cyc("R2", 0, 0, 2'd0, 0, 1, i[0]);
    cyc("R2", 0, 1, 2'd0, 0, 0, 0);
    check("R2 ext count", last_rd[1], 16'd5);
    check("R2 div ignores bit8", last_rd[0], 16'd10);

    // R4 overflow wrap
    cyc("R4", 1, 0, 2'd1, 16'h0020, 0, 0);
    cyc("R4", 1, 0, 2'd0, 16'hFFFE, 0, 0);
    irq_seen[0] = 0;
    idle(2, 1, 0);
    cyc("R4", 0, 1, 2'd0, 0, 0, 0); check("R4 wrapped", last_rd[0], 16'd0);
    cyc("R5", 0, 1, 2'd1, 0, 0, 0); check("R5 ovf flag", last_rd[0] & 16'h1400, 16'h1400);
    check("R7 ovf pulse", 16'(irq_seen[0]), 16'd1);

    // random traffic checked against the model
    for (int n = 0; n < 6000; n++) begin
      int unsigned r;
      logic [1:0]  a;
      logic [15:0] d;
      bit s, e;
      r = $urandom_range(99);
      s = ($urandom_range(9) < 7);
      e = $urandom_range(1);
      a = 2'($urandom_range(3));
      if (r < 65) cyc("R4 rnd", 0, 0, a, 0, s, e);
      else if (r < 80) cyc("R6 rnd", 0, 1, a, 0, s, e);
      else if (r < 87) begin
        d = ($urandom_range(3) == 0) ? 16'hFFF0 + 16'($urandom_range(15)) : 16'($urandom_range(40));
        cyc("R11 rnd", 1, 0, 2'd0, d, s, e);
      end else if (r < 94) cyc("R10 rnd", 1, 0, 2'd2, 16'($urandom_range(40)), s, e);
      else begin
        d = 16'($urandom) & 16'hFF7E;
        if ($urandom_range(7) == 0) d[0] = 1'b1;
        cyc("R9 rnd", 1, 0, 2'd1, d, s, e);
      end
    end

    summary();
  end

endmodule